// File: doc/BRIEF.md
# Sixty-Four Line Interrupt Pending Controller

This block collects 64 interrupt request lines and decides which ones are serviced and which parent output each one drives. Each line is set to edge mode or level mode. An edge line latches a pending flag when its input rises. A level line's pending flag follows its input. When an event makes a line eligible, that line becomes in service: it is pending, it is not masked, and the event concerns it. The parent output named by the line's entry in a byte-wide target table is then driven high. When a line stops being pending, or software retires it, that output is driven low.

Software reaches the block through a small register port. The 64-bit mask, mode, enable and polarity registers are written as 32-bit halves. The two 64-entry byte tables are written one byte at a time. A read returns the 64-bit word that contains the address, shifted down by the byte offset and cut to the requested size. The port has no back-pressure. A write takes effect at the clock edge where `reg_wr` is sampled high. A read is answered one cycle later, with `rd_valid` high for exactly one cycle. Software must not issue a read and a write in the same cycle.

All interrupt pins and outputs are plain levels, sampled and updated on every clock. Polarity, the enable register and the second byte table only hold their values and do not change behaviour.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Reset clears all state: pending, in service, previous input levels, every register and both tables. After reset `par_irq` is zero, every read returns zero and `rd_valid` is low.
- R2: A line with its mode bit set to 1 (edge) becomes pending only when its input is high in a cycle where it was low in the cycle before. A falling input never clears that pending flag. If the line is unmasked when it rises, it enters service and the output selected by its target entry goes high on the following clock edge.
- R3: A line with its mode bit 0 (level) is pending exactly while its input stays high. Its rise puts an unmasked line in service and drives its output high. Its fall takes it out of service and drives that output low.
- R4: A masked line that becomes pending does not enter service and does not change any output.
- R5: A mask write that unmasks several pending lines puts only the lowest-numbered of them in service and drives only that line's output high. A mask write that masks a line which is in service but no longer pending retires the lowest such line and drives its output low.
- R6: The mask register is at byte 0x00, the mode register at 0x08, the enable register at 0x10 and the polarity register at 0x38. A write to offset +0 replaces bits 31:0 and a write to offset +4 replaces bits 63:32. The other half keeps its value.
- R7: A write to the clear register (0x18 low half, 0x1C high half) acts only when at least one written bit belongs to an edge line. It then clears pending and in-service for every written bit, and drives low only the output of the lowest written line that was in service. Outputs of the other cleared lines stay as they were. If no written bit is an edge line, the write changes nothing.
- R8: The status word at 0x30 reads as in-service AND NOT mask. The two control words at 0x20 and 0x28 read as zero and ignore writes. The clear register reads as zero.
- R9: The target table sits at bytes 0x100 to 0x13F (entry n at 0x100+n) and the second table at 0x180 to 0x1BF. Each entry is written from `reg_wdata[7:0]`. Writes to 0x140 to 0x17F and 0x1C0 to 0x1FF are ignored, and those bytes read as zero.
- R10: A target entry of 64 or more selects no parent output. The line still enters and leaves service.
- R11: A read with `reg_size` 0, 1, 2 or 3 (1, 2, 4 or 8 bytes) returns the containing 64-bit word shifted right by 8 times `reg_addr[2:0]` and masked to that width. `rd_valid` goes high in the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 64 | Interrupt request lines, sampled every clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte address |
| reg_wdata | input | 32 | Write data: a 32-bit half, or a table byte in bits 7:0 |
| reg_size | input | 2 | Read width code: 0=1, 1=2, 2=4, 3=8 bytes |
| rd_valid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rd_data | output | 64 | Read data, zero-extended |
| par_irq | output | N_OUT | Parent interrupt outputs |

## Verification
Every result is due one clock edge after its stimulus. An input change or a register write sampled at edge k shows on `par_irq` and in the internal state right after edge k. A read strobe sampled at edge k puts `rd_data` and `rd_valid` in place right after edge k. The bench drives every stimulus on the falling edge. It samples outputs on the next falling edge, half a period after the edge that acts on them. Each check therefore lands in the exact cycle its result is due, and never at an edge where values are still changing.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int LINES  = 64;
  localparam int HALF   = LINES / 2;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;

  typedef logic [LINES-1:0] line_vec_t;

  // word index (addr[5:3]) inside the register window 0x000-0x03F
  localparam logic [2:0] W_MASK  = 3'd0;
  localparam logic [2:0] W_MODE  = 3'd1;
  localparam logic [2:0] W_ENAB  = 3'd2;
  localparam logic [2:0] W_CLEAR = 3'd3;
  localparam logic [2:0] W_CTLA  = 3'd4;
  localparam logic [2:0] W_CTLB  = 3'd5;
  localparam logic [2:0] W_STAT  = 3'd6;
  localparam logic [2:0] W_POL   = 3'd7;

  typedef struct packed {
    line_vec_t unmasked;
    line_vec_t masked;
    line_vec_t clr_bits;
    logic      clr_go;
  } reg_evt_t;

  // isolate lowest set bit
  function automatic line_vec_t lowest_one(line_vec_t v);
    return v & (~v + line_vec_t'(1));
  endfunction
endpackage

// File: rtl/ipc_track.sv
module ipc_track
  import ipc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  line_vec_t mode_q,
  input  line_vec_t clr_bits,
  output line_vec_t rise,
  output line_vec_t fall,
  output line_vec_t pend_mid,
  output line_vec_t pend_q
);
  line_vec_t last_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign rise[i] = irq_in[i] & ~last_q[i];
    assign fall[i] = ~irq_in[i] & last_q[i];
    // edge lines ignore falls; level lines drop pending on a fall
    assign pend_mid[i] = (pend_q[i] | rise[i]) & ~(fall[i] & ~mode_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        last_q[i] <= irq_in[i];
        pend_q[i] <= pend_mid[i] & ~clr_bits[i];
      end
    end
  end
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
  import ipc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [HALF-1:0]               wdata,
  input  logic [1:0]                    rd_size,
  input  line_vec_t                     isr_q,
  output line_vec_t                     mask_q,
  output line_vec_t                     mask_nx,
  output line_vec_t                     mode_q,
  output logic [LINES-1:0][VEC_W-1:0]   tgt_q,
  output reg_evt_t                      evt,
  output logic                          rd_valid,
  output logic [63:0]                   rd_data
);
  line_vec_t enab_q, pol_q, cbits, word;
  logic [LINES-1:0][BYTE_W-1:0] tag_q;
  logic word_sel, tgt_sel, tag_sel, ent_ok, hi, wr_word, clr_req;
  logic [2:0] widx;
  logic [5:0] ent;
  logic [63:0] shifted;

  assign word_sel = (addr[8:6] == 3'b000);
  assign tgt_sel  = (addr[8:7] == 2'b10);
  assign tag_sel  = (addr[8:7] == 2'b11);
  assign ent_ok   = ~addr[6];
  assign ent      = addr[5:0];
  assign widx     = addr[5:3];
  assign hi       = addr[2];
  assign wr_word  = wr_en & word_sel;

  function automatic line_vec_t merge_half(line_vec_t old, logic up, logic [HALF-1:0] d);
    return up ? {d, old[HALF-1:0]} : {old[LINES-1:HALF], d};
  endfunction

  assign mask_nx = (wr_word && widx == W_MASK) ? merge_half(mask_q, hi, wdata) : mask_q;
  assign cbits   = hi ? {wdata, {HALF{1'b0}}} : {{HALF{1'b0}}, wdata};
  assign clr_req = wr_word && (widx == W_CLEAR);

  always_comb begin
    evt.unmasked = mask_q & ~mask_nx;
    evt.masked   = ~mask_q & mask_nx;
    evt.clr_go   = clr_req && ((cbits & mode_q) != '0);
    evt.clr_bits = evt.clr_go ? cbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      enab_q <= '0;
      pol_q  <= '0;
      tgt_q  <= '0;
      tag_q  <= '0;
    end else begin
      mask_q <= mask_nx;
      if (wr_word && widx == W_MODE) mode_q <= merge_half(mode_q, hi, wdata);
      if (wr_word && widx == W_ENAB) enab_q <= merge_half(enab_q, hi, wdata);
      if (wr_word && widx == W_POL)  pol_q  <= merge_half(pol_q, hi, wdata);
      if (wr_en && tgt_sel && ent_ok) tgt_q[ent] <= wdata[VEC_W-1:0];
      if (wr_en && tag_sel && ent_ok) tag_q[ent] <= wdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    word = '0;
    if (word_sel) begin
      unique case (widx)
        W_MASK:  word = mask_q;
        W_MODE:  word = mode_q;
        W_ENAB:  word = enab_q;
        W_STAT:  word = isr_q & ~mask_q;
        W_POL:   word = pol_q;
        default: word = '0;
      endcase
    end else if ((tgt_sel || tag_sel) && ent_ok) begin
      for (int b = 0; b < 8; b++) begin
        word[b*8 +: 8] = tgt_sel ? BYTE_W'(tgt_q[{widx, b[2:0]}]) : tag_q[{widx, b[2:0]}];
      end
    end
  end

  assign shifted = word >> {addr[2:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (rd_size)
          2'd0: rd_data <= {56'd0, shifted[7:0]};
          2'd1: rd_data <= {48'd0, shifted[15:0]};
          2'd2: rd_data <= {32'd0, shifted[31:0]};
          default: rd_data <= shifted;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipc_dispatch.sv
module ipc_dispatch
  import ipc_pkg::*;
#(
  parameter int N_OUT = 64,
  parameter int VEC_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  line_vec_t                   rise,
  input  line_vec_t                   fall,
  input  line_vec_t                   pend_mid,
  input  line_vec_t                   mask_nx,
  input  line_vec_t                   unmasked,
  input  line_vec_t                   masked,
  input  line_vec_t                   clr_bits,
  input  logic [LINES-1:0][VEC_W-1:0] tgt_q,
  output line_vec_t                   isr_q,
  output logic [N_OUT-1:0]            par_q
);
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  line_vec_t pend_cl, up_lines, dn_lines, isr_nx;
  logic [N_OUT-1:0] drv_hi, drv_lo;

  always_comb begin
    pend_cl  = pend_mid & ~clr_bits;
    // input events: each changed line is its own event
    up_lines = (rise & pend_mid & ~mask_nx)
             | lowest_one(unmasked & pend_mid);
    dn_lines = (fall & isr_q & ~pend_mid)
             | lowest_one(masked & isr_q & ~pend_mid)
             | lowest_one(clr_bits & isr_q & ~pend_cl);
    isr_nx   = (isr_q & ~dn_lines & ~clr_bits) | up_lines;
  end

  always_comb begin
    drv_hi = '0;
    drv_lo = '0;
    for (int i = 0; i < LINES; i++) begin
      if (int'(tgt_q[i]) < N_OUT) begin
        if (up_lines[i]) drv_hi[tgt_q[i][OW-1:0]] = 1'b1;
        if (dn_lines[i]) drv_lo[tgt_q[i][OW-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      par_q <= '0;
    end else begin
      isr_q <= isr_nx;
      par_q <= (par_q & ~drv_lo) | drv_hi;
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import ipc_pkg::*;
#(
  parameter int N_OUT = 64,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES-1:0]     irq_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [HALF-1:0]      reg_wdata,
  input  logic [1:0]           reg_size,
  output logic                 rd_valid,
  output logic [63:0]          rd_data,
  output logic [N_OUT-1:0]     par_irq
);
  line_vec_t mask_q, mask_nx, mode_q, isr_q, pend_q, pend_mid, rise, fall;
  logic [LINES-1:0][VEC_W-1:0] tgt_q;
  reg_evt_t evt;

  ipc_regs #(.VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .rd_size(reg_size),
    .isr_q(isr_q), .mask_q(mask_q), .mask_nx(mask_nx), .mode_q(mode_q),
    .tgt_q(tgt_q), .evt(evt), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  ipc_track u_track (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_q(mode_q),
    .clr_bits(evt.clr_bits), .rise(rise), .fall(fall),
    .pend_mid(pend_mid), .pend_q(pend_q)
  );

  ipc_dispatch #(.N_OUT(N_OUT), .VEC_W(VEC_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .pend_mid(pend_mid),
    .mask_nx(mask_nx), .unmasked(evt.unmasked), .masked(evt.masked),
    .clr_bits(evt.clr_bits), .tgt_q(tgt_q), .isr_q(isr_q), .par_q(par_irq)
  );
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
  import ipc_pkg::*;
#(
  parameter int N_OUT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             rd_valid,
  input logic [N_OUT-1:0] par_irq,
  input line_vec_t        isr_q,
  input line_vec_t        pend_q,
  input line_vec_t        mode_q,
  input line_vec_t        mask_q,
  input line_vec_t        rise,
  input logic             clr_go,
  input line_vec_t        clr_bits,
  input line_vec_t        unmasked
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (par_irq == '0 && isr_q == '0 && !rd_valid));

  // R2: an edge line's pending flag drops only through the clear register
  p_edge_pend_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q & $past(mode_q) & ~$past(clr_bits)) == '0));

  p_out_needs_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((par_irq & ~$past(par_irq)) != '0) |-> (isr_q != '0));

  p_masked_no_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q) & mask_q) == '0));

  p_unmask_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked != '0 && rise == '0) |=> ($countones(isr_q & ~$past(isr_q)) <= 1));

  p_clear_ends_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_go && rise == '0) |=> ((isr_q & $past(clr_bits)) == '0));

  p_read_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);

  p_no_stray_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid);
endmodule

bind irq_pend_ctrl ipc_checker #(.N_OUT(N_OUT)) u_ipc_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .rd_valid(rd_valid),
  .par_irq(par_irq), .isr_q(isr_q), .pend_q(pend_q), .mode_q(mode_q),
  .mask_q(mask_q), .rise(rise), .clr_go(evt.clr_go),
  .clr_bits(evt.clr_bits), .unmasked(evt.unmasked)
);

// File: tb/test_irq_pend_ctrl.sv
module test_irq_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_size = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [63:0] par_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_par = '0;
  logic        last_vld;

  always #2 clk = ~clk;

  irq_pend_ctrl i_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_size(reg_size),
    .rd_valid(rd_valid), .rd_data(rd_data), .par_irq(par_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [1:0] sz, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rd_data;
    last_vld = rd_valid;
  endtask

  task automatic drive(input int line, input logic v);
    @(negedge clk);
    irq_in[line] = v;
    @(negedge clk);
  endtask

  task automatic chk_par(input string req);
    chk(par_irq == exp_par, req, par_irq, exp_par);
  endtask

  task automatic chk_read(input logic [8:0] a, input logic [1:0] sz, input logic [63:0] exp, input string req);
    logic [63:0] d;
    rd(a, sz, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset;
    chk_par("R1 outputs after reset");
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    chk_read(9'h000, 2'd3, 64'd0, "R1 mask reset");
    chk_read(9'h030, 2'd3, 64'd0, "R1 status reset");
    chk_read(9'h100, 2'd3, 64'd0, "R1 target table reset");
  endtask

  task automatic t_halves;
    wr(9'h008, 32'h0123_4567);
    wr(9'h00C, 32'h89AB_CDEF);
    chk_read(9'h008, 2'd3, 64'h89AB_CDEF_0123_4567, "R6 two halves");
    chk(last_vld == 1'b1, "R11 rd_valid after read", 64'(last_vld), 64'd1);
    chk_read(9'h00B, 2'd0, 64'h01, "R11 one byte at offset 3");
    chk_read(9'h00A, 2'd1, 64'h0123, "R11 two bytes at offset 2");
    chk_read(9'h00C, 2'd2, 64'h89AB_CDEF, "R11 four bytes at offset 4");
    chk_read(9'h00D, 2'd3, 64'h0000_0000_0089_ABCD, "R11 eight bytes at offset 5");
    wr(9'h008, 32'h0000_00F0);
    chk_read(9'h008, 2'd3, 64'h89AB_CDEF_0000_00F0, "R6 low write keeps high half");
    wr(9'h00C, 32'h0);
    wr(9'h038, 32'hFFFF_FFFF);
    chk_read(9'h038, 2'd3, 64'h0000_0000_FFFF_FFFF, "R6 polarity low half");
    wr(9'h014, 32'h1234_5678);
    chk_read(9'h010, 2'd3, 64'h1234_5678_0000_0000, "R6 enable high half");
  endtask

  task automatic t_tables;
    wr(9'h104, 32'd3);
    wr(9'h105, 32'd5);
    wr(9'h106, 32'd13);
    wr(9'h107, 32'd14);
    wr(9'h10A, 32'd7);
    wr(9'h10C, 32'd200);
    chk_read(9'h100, 2'd3, 64'h0E0D_0503_0000_0000, "R9 target bytes 0-7");
    wr(9'h181, 32'h5A);
    chk_read(9'h181, 2'd0, 64'h5A, "R9 second table byte");
    wr(9'h140, 32'h77);
    chk_read(9'h140, 2'd0, 64'h0, "R9 write past 64 entries ignored");
    wr(9'h1C3, 32'h66);
    chk_read(9'h1C0, 2'd3, 64'h0, "R9 second table past 64 entries ignored");
  endtask

  task automatic t_level;
    drive(10, 1'b1);
    exp_par[7] = 1'b1;
    chk_par("R3 level rise drives target 7");
    chk_read(9'h030, 2'd3, 64'h400, "R3 status shows line 10");
    drive(10, 1'b0);
    exp_par[7] = 1'b0;
    chk_par("R3 level fall releases target 7");
    chk_read(9'h030, 2'd3, 64'h0, "R3 status clear after fall");
  endtask

  task automatic t_edge;
    drive(5, 1'b1);
    exp_par[5] = 1'b1;
    chk_par("R2 edge rise drives target 5");
    drive(5, 1'b0);
    chk_par("R2 edge fall leaves output high");
    chk_read(9'h030, 2'd3, 64'h20, "R2 edge line stays in service");
  endtask

  task automatic t_clear;
    drive(4, 1'b1);
    exp_par[3] = 1'b1;
    chk_par("R2 second edge line drives target 3");
    wr(9'h018, 32'h30);
    exp_par[3] = 1'b0;
    chk_par("R7 clear lowers only lowest line output");
    chk_read(9'h030, 2'd3, 64'h0, "R7 clear ends service of both lines");
    drive(10, 1'b1);
    exp_par[7] = 1'b1;
    chk_par("R3 level line back in service");
    wr(9'h018, 32'h400);
    chk_par("R7 clear of level-only bits has no effect");
    chk_read(9'h030, 2'd3, 64'h400, "R7 level line still in service");
    chk_read(9'h018, 2'd3, 64'h0, "R8 clear register reads zero");
    drive(10, 1'b0);
    exp_par[7] = 1'b0;
    drive(4, 1'b0);
    drive(5, 1'b0);
    chk_par("R7 outputs after releasing inputs");
  endtask

  task automatic t_mask;
    wr(9'h000, 32'hC0);
    @(negedge clk);
    irq_in[6] = 1'b1;
    irq_in[7] = 1'b1;
    @(negedge clk);
    chk_par("R4 masked rises leave outputs");
    chk_read(9'h030, 2'd3, 64'h0, "R4 masked lines not in service");
    wr(9'h000, 32'h0);
    exp_par[13] = 1'b1;
    chk_par("R5 unmask serves only lowest line");
    chk_read(9'h030, 2'd3, 64'h40, "R5 only line 6 in service");
    wr(9'h000, 32'h80);
    chk_par("R5 masking idle line changes nothing");
    wr(9'h000, 32'h40);
    exp_par[14] = 1'b1;
    chk_par("R5 unmasking line 7 serves it");
    chk_read(9'h030, 2'd3, 64'h80, "R8 status hides masked line 6");
    wr(9'h000, 32'h0);
    chk_read(9'h030, 2'd3, 64'hC0, "R8 status with empty mask");
  endtask

  task automatic t_novec;
    drive(12, 1'b1);
    chk_par("R10 target 200 drives no output");
    chk_read(9'h030, 2'd3, 64'h10C0, "R10 line 12 still in service");
    drive(12, 1'b0);
    chk_read(9'h030, 2'd3, 64'hC0, "R10 line 12 leaves service");
  endtask

  task automatic t_top_line;
    drive(63, 1'b1);
    exp_par[0] = 1'b1;
    chk_par("R3 line 63 drives target 0");
    chk_read(9'h034, 2'd2, 64'h8000_0000, "R11 status high half");
    drive(63, 1'b0);
    exp_par[0] = 1'b0;
    chk_par("R3 line 63 fall");
  endtask

  task automatic t_ctl;
    wr(9'h020, 32'hFFFF_FFFF);
    wr(9'h02C, 32'hFFFF_FFFF);
    chk_read(9'h020, 2'd3, 64'h0, "R8 control word A reads zero");
    chk_read(9'h028, 2'd3, 64'h0, "R8 control word B reads zero");
    chk_par("R8 control writes leave outputs");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halves();
    t_tables();
    t_level();
    t_edge();
    t_clear();
    t_mask();
    t_novec();
    t_top_line();
    t_ctl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule